// File: doc/BRIEF.md
# Floored Constant Modulo Unit

This block reduces a signed two's-complement word modulo a fixed positive constant and returns the floored remainder. The floored remainder takes the sign of the divisor, so the result always lies in 0 to MOD-1, even for negative inputs. The truncating `%` operator would return a negative remainder for those inputs instead. With MOD = 6434, an input of -6310 yields 124. With the default MOD = 12868, the same input yields 6558. The block produces no quotient and contains no general divider.

The computation is spread over a short pipeline so that it fits a fast clock.

- The first stage folds a negative input into a non-negative range by adding FOLD·MOD. FOLD is the smallest multiple that covers the most negative input.
- Each following stage performs one compare-and-conditional-subtract of a power-of-two multiple of MOD.
- The stage count is derived from the parameters. At the default it is three register stages.

Both sides of the block use valid/ready handshakes.

- A transfer happens on a clock edge where valid and ready are both high.
- The whole pipeline advances together. It holds when its last stage holds a result that the consumer is not taking.
- `in_ready` is high whenever `out_ready` is high or the output stage is empty. A producer may therefore push one word per cycle while the consumer keeps up.
- While `out_valid` is high and `out_ready` is low, the output word stays unchanged.

Top module: `floored_mod`

## Requirements
- R1: For a non-negative input y, `out_data` equals y mod MOD, with MOD = 12868 by default.
- R2: For a negative input y, `out_data` equals y - MOD·floor(y/MOD), a non-negative value. For example, -6310 gives 6558 with MOD = 12868 and 124 with MOD = 6434.
- R3: Whenever `out_valid` is high, `out_data` is strictly less than MOD.
- R4: With `out_ready` held high, a word accepted at one edge appears at the output 1 + ceil(log2(FOLD)) edges later. FOLD = ceil(2^(IN_W-1)/MOD), which gives 3 edges at the default and 4 edges for MOD = 6434. `in_ready` stays high, so one word is accepted every cycle.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values at the next edge. Once every stage is occupied, `in_ready` is low.
- R7: An active-low synchronous reset (`rst_n` = 0 at an edge) empties every stage, so `out_valid` is low after that edge.
- R8: The extreme inputs -32768 and 32767 reduce correctly.
- R9: The parameter MOD = 6434 gives correct floored results for every 16-bit input.
- R10: Every accepted word produces exactly one output word, in acceptance order. No output appears without a matching accepted input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | IN_W | Signed dividend, two's complement |
| out_valid | output | 1 | Remainder present |
| out_ready | input | 1 | Consumer takes the remainder this cycle |
| out_data | output | OUT_W | Floored remainder, 0 to MOD-1 |

## Verification
The bound checker watches four properties on every cycle:

- the output range;
- the hold of the output word under back-pressure;
- the emptying of the pipeline by reset;
- a running count of words in flight, which must never go negative or exceed the pipeline depth.

The numeric value of each remainder, the exact latency, the full-rate throughput and the acceptance order can only be shown by the bench's scenarios. The bench sweeps every 16-bit input through two instances, one with MOD = 12868 and one with MOD = 6434. It compares each output against an arithmetic floored-modulo model.

// File: rtl/fmod_pkg.sv
`timescale 1ns/1ps
package fmod_pkg;
  // Smallest k such that k*m covers the magnitude of the most negative input.
  function automatic int unsigned fm_fold_mult(int unsigned in_w, int unsigned m);
    return ((32'd1 << (in_w - 1)) + m - 1) / m;
  endfunction
endpackage

// File: rtl/fm_fold_stage.sv
`timescale 1ns/1ps
module fm_fold_stage #(
  parameter int unsigned IN_W = 16,
  parameter int unsigned VW   = 16,
  parameter int unsigned SPAN = 38604
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  output logic [VW-1:0]          out_data
);
  localparam logic [VW-1:0] SPAN_V = VW'(SPAN);

  logic [IN_W-1:0] magnitude;
  logic [VW-1:0]   folded;

  // A negative y maps to SPAN - |y|, which is in [0, SPAN) and congruent to y.
  assign magnitude = IN_W'(~in_data + 1'b1);
  assign folded    = in_data[IN_W-1] ? (SPAN_V - VW'(magnitude))
                                     : VW'($unsigned(in_data));

  always_ff @(posedge clk) begin
    if (!rst_n)  out_valid <= 1'b0;
    else if (en) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) out_data <= folded;
  end
endmodule

// File: rtl/fm_sub_stage.sv
`timescale 1ns/1ps
module fm_sub_stage #(
  parameter int unsigned VW  = 16,
  parameter int unsigned SUB = 12868
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [VW-1:0] in_data,
  output logic          out_valid,
  output logic [VW-1:0] out_data
);
  localparam logic [VW-1:0] SUB_V = VW'(SUB);

  logic [VW-1:0] reduced;
  assign reduced = (in_data >= SUB_V) ? (in_data - SUB_V) : in_data;

  always_ff @(posedge clk) begin
    if (!rst_n)  out_valid <= 1'b0;
    else if (en) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (en) out_data <= reduced;
  end
endmodule

// File: rtl/floored_mod.sv
`timescale 1ns/1ps
module floored_mod #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned MOD   = 12868,
  parameter int unsigned OUT_W = $clog2(MOD)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic signed [IN_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [OUT_W-1:0]       out_data
);
  import fmod_pkg::*;

  localparam int unsigned FOLD  = fm_fold_mult(IN_W, MOD);
  localparam int unsigned NSTEP = $clog2(FOLD);
  localparam int unsigned SPAN  = FOLD * MOD;
  localparam int unsigned VW    = $clog2(SPAN);

  logic [VW-1:0] st_d [0:NSTEP];
  logic          st_v [0:NSTEP];
  logic          adv;

  // The whole pipeline moves together unless a result waits at the output.
  assign adv      = out_ready | ~st_v[NSTEP];
  assign in_ready = adv;

  fm_fold_stage #(.IN_W(IN_W), .VW(VW), .SPAN(SPAN)) u_fold (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(st_v[0]), .out_data(st_d[0])
  );

  // Stage g strips MOD * 2^(NSTEP-1-g); after it the value is below that bound.
  for (genvar g = 0; g < NSTEP; g++) begin : g_sub
    fm_sub_stage #(.VW(VW), .SUB(MOD << (NSTEP - 1 - g))) u_sub (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .in_valid(st_v[g]), .in_data(st_d[g]),
      .out_valid(st_v[g+1]), .out_data(st_d[g+1])
    );
  end

  assign out_valid = st_v[NSTEP];
  assign out_data  = st_d[NSTEP][OUT_W-1:0];
endmodule

// File: rtl/floored_mod_chk.sv
`timescale 1ns/1ps
module floored_mod_chk #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned MOD   = 12868,
  parameter int unsigned OUT_W = 14
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic signed [IN_W-1:0] in_data,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [OUT_W-1:0]       out_data
);
  import fmod_pkg::*;

  localparam int unsigned LAT = $clog2(fm_fold_mult(IN_W, MOD)) + 1;

  logic [7:0] inflight;
  logic       took_in;
  logic       gave_out;

  assign took_in  = in_valid & in_ready;
  assign gave_out = out_valid & out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= 8'd0;
    else        inflight <= inflight + {7'd0, took_in} - {7'd0, gave_out};
  end

  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (32'(out_data) < MOD));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_flush_r7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  p_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (inflight != 8'd0));

  p_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(inflight) <= LAT);
endmodule

bind floored_mod floored_mod_chk #(.IN_W(IN_W), .MOD(MOD), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/floored_mod_tb_top.sv
`timescale 1ns/1ps
module floored_mod_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n;
  logic               in_valid;
  logic signed [15:0] in_data;
  logic               out_ready;
  logic               a_ir, a_ov, b_ir, b_ov;
  logic [13:0]        a_od;
  logic [12:0]        b_od;

  floored_mod #(.IN_W(16), .MOD(12868)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(a_ir),
    .in_data(in_data), .out_valid(a_ov), .out_ready(out_ready), .out_data(a_od)
  );

  floored_mod #(.IN_W(16), .MOD(6434)) dut_b_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(b_ir),
    .in_data(in_data), .out_valid(b_ov), .out_ready(out_ready), .out_data(b_od)
  );

  int nchk  = 0;
  int nfail = 0;
  int qa[$];
  int qb[$];
  int ya, yb;

  function automatic int ref_mod(int y, int m);
    int r;
    r = y % m;
    if (r < 0) r += m;
    return r;
  endfunction

  function automatic string tag_of(int y);
    if (y == -32768 || y == 32767) return "R8";
    if (y < 0) return "R2";
    return "R1";
  endfunction

  task automatic check(int act, int exp, string req);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard: outputs are compared and handshakes recorded between edges.
  always @(negedge clk) begin
    if (rst_n) begin
      if (a_ov && out_ready) begin
        if (qa.size() == 0) check(1, 0, "R10 spurious output MOD 12868");
        else begin
          ya = qa.pop_front();
          check(int'(a_od), ref_mod(ya, 12868), tag_of(ya));
        end
      end
      if (b_ov && out_ready) begin
        if (qb.size() == 0) check(1, 0, "R10 spurious output MOD 6434");
        else begin
          yb = qb.pop_front();
          check(int'(b_od), ref_mod(yb, 6434), {"R9 ", tag_of(yb)});
        end
      end
      if (in_valid && a_ir) qa.push_back(int'(in_data));
      if (in_valid && b_ir) qb.push_back(int'(in_data));
    end
  end

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    int ca, cb, held;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(int'(a_ov), 0, "R7 reset state");
    check(int'(b_ov), 0, "R7 reset state");
    rst_n = 1'b1;

    // R4 latency, and the worked R2 example
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = -16'sd6310;
    @(posedge clk); #1;
    in_valid = 1'b0;
    ca = 0; cb = 0;
    for (int c = 1; c <= 8; c++) begin
      if (a_ov && ca == 0) begin ca = c; check(int'(a_od), 6558, "R2 -6310 mod 12868"); end
      if (b_ov && cb == 0) begin cb = c; check(int'(b_od), 124, "R2 -6310 mod 6434"); end
      @(posedge clk); #1;
    end
    check(ca, 3, "R4 latency MOD 12868");
    check(cb, 4, "R4 latency MOD 6434");

    // Exhaustive sweep at full rate (R1, R2, R8, R9)
    for (int i = 0; i < 65536; i++) begin
      in_valid = 1'b1; in_data = 16'(i);
      if (i % 4096 == 0) begin
        check(int'(a_ir), 1, "R4 throughput");
        check(int'(b_ir), 1, "R4 throughput");
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    repeat (8) @(posedge clk);
    #1;
    check(qa.size(), 0, "R10 all delivered MOD 12868");
    check(qb.size(), 0, "R10 all delivered MOD 6434");

    // R5 back-pressure
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) begin
      in_valid = 1'b1; in_data = 16'(i * 5003 - 20000);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    check(int'(a_ir), 0, "R5 full pipeline MOD 12868");
    check(int'(b_ir), 0, "R5 full pipeline MOD 6434");
    check(int'(a_ov), 1, "R5 output waiting");
    held = int'(a_od);
    repeat (5) @(posedge clk);
    #1;
    check(int'(a_ov), 1, "R5 valid held");
    check(int'(a_od), held, "R5 data held");
    out_ready = 1'b1;
    repeat (8) @(posedge clk);
    #1;
    check(qa.size(), 0, "R10 drained after stall MOD 12868");
    check(qb.size(), 0, "R10 drained after stall MOD 6434");

    // R7 reset with words in flight
    in_valid = 1'b1; in_data = 16'sd1234;
    @(posedge clk); #1;
    in_data = -16'sd32768;
    @(posedge clk); #1;
    in_valid = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    check(int'(a_ov), 0, "R7 flush MOD 12868");
    check(int'(b_ov), 0, "R7 flush MOD 6434");
    qa.delete(); qb.delete();
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    check(int'(a_ov), 0, "R7 nothing after flush");
    check(int'(b_ov), 0, "R7 nothing after flush");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule